// File: doc/BRIEF.md
# Host Command and Register Unit for a Single-Wire Bus Bridge

This unit is the command front end of a bridge that lets a byte-oriented host drive a single-wire bus. A bit-level I2C target shim hands it each received byte together with start, stop and read-access events, and takes back an acknowledge decision for every byte within the cycle it is offered. The unit decodes one-byte command codes with their optional parameter byte and holds the configuration, status and read-data registers. A read pointer selects which register is returned on host reads.

Bus operations (reset/presence, single bit, byte write, byte read, search triplet) are handed to a waveform sequencer through a one-cycle start pulse with an opcode and an argument byte. The sequencer answers with a done pulse and result fields, which the unit folds into its registers. While an operation is in flight the unit refuses every command that would touch the bus or the configuration. Only a device reset or a pointer change is accepted at such times.

Top module: `hcr_top`

## Requirements
- R1: After power-on reset the status register reads 10h (only the reset flag, bit 4, set), the configuration register reads 00h, and the read pointer selects status.
- R2: Codes B4h (bus reset, opcode 0) and 96h (byte read, opcode 3) launch on the code byte. Codes 87h (single bit, opcode 1, bit value in argument bit 7), A5h (byte write, opcode 2) and 78h (triplet, opcode 4) launch on their parameter byte, which is passed unchanged as the argument.
- R3: Code E1h followed by F0h, E1h or C3h selects status, read data or configuration and is acknowledged. Any other pointer byte is NACKed and leaves the pointer unchanged.
- R4: Code D2h followed by a byte whose bits 7:4 equal the inverse of bits 3:0 is acknowledged. It loads bits 3:0 into the configuration, clears the reset flag and selects configuration. Any other byte is NACKed and changes nothing. A configuration read always shows 0 in bits 7:4.
- R5: While the busy bit (status bit 0) is 1, codes D2h, B4h, 87h, A5h, 96h and 78h are NACKed and start nothing. F0h and E1h are still accepted.
- R6: Code F0h is always acknowledged. It sets status to 10h and configuration to 00h, selects status, and pulses the abort output one cycle later.
- R7: Every launched bus operation sets the busy bit and selects status. The busy bit clears after the sequencer's done pulse.
- R8: On completion, a bus reset writes presence into bit 1 and short into bit 2, with presence forced to 0 when a short is reported. A single bit writes its sampled value into bit 5. A triplet writes bits 5, 6 and 7 (first bit, second bit, direction). A byte read loads the read-data register. A byte write changes no result bit.
- R9: Unknown codes and every byte after the last expected byte of a command are NACKed and ignored.
- R10: The selected register is presented for every read without re-addressing. Line-level bit 3 is sampled from the bus line when a read access begins, but only while status is selected.
- R11: A stop or a new start discards a partially received command, so the next byte is decoded as a command code.
- R12: The strong-pullup configuration bit (bit 2) clears when the sequencer reports that the strong pullup has ended. The other configuration bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| rx_valid | input | 1 | A written byte is offered this cycle |
| rx_byte | input | 8 | Offered byte |
| ack | output | 1 | Acknowledge decision for the offered byte |
| bus_start | input | 1 | Start or repeated start seen |
| bus_stop | input | 1 | Stop seen |
| rd_begin | input | 1 | Host read access begins |
| rd_data | output | 8 | Register selected by the read pointer |
| line_in | input | 1 | Current level of the single-wire line |
| op_start | output | 1 | One-cycle launch pulse to the sequencer |
| op_code | output | 3 | Operation: 0 reset, 1 bit, 2 write byte, 3 read byte, 4 triplet |
| op_arg | output | 8 | Operation argument byte |
| seq_done | input | 1 | Sequencer finished the operation |
| res_presence | input | 1 | Presence detected during bus reset |
| res_short | input | 1 | Short detected during bus reset |
| res_bit1 | input | 1 | Sampled value of single bit or first triplet bit |
| res_bit2 | input | 1 | Sampled value of second triplet bit |
| res_dir | input | 1 | Direction taken by the triplet |
| res_data | input | 8 | Byte received by a byte read |
| spu_end | input | 1 | Strong pullup has ended |
| abort | output | 1 | Pulse that terminates sequencer activity |
| cfg_bits | output | 4 | Configuration: 0 active pullup, 1 presence mask, 2 strong pullup, 3 speed |

## Verification
Several rules are checked by assertions on every cycle: a command code offered while busy is never acknowledged, bytes past the end of a command are never acknowledged, a launch only happens when idle and always raises busy, and a device reset leaves the exact reset image. The same holds for an accepted configuration write landing in the register and for short and presence never being reported together. Sweeps over all 256 configuration bytes, all 256 pointer codes and all 256 command codes while busy show the acceptance rules in full. Scenarios with a modelled sequencer show the opcode and argument hand-off, how results are folded into status, line sampling only while status is selected, discarding of partial commands, and the strong-pullup clear.

// File: rtl/hcr_pkg.sv
`timescale 1ns/1ps
package hcr_pkg;
  localparam int BYTE_W = 8;
  localparam int CFG_W  = BYTE_W / 2;

  localparam logic [BYTE_W-1:0] C_DEVRST = 8'hF0;
  localparam logic [BYTE_W-1:0] C_SETPTR = 8'hE1;
  localparam logic [BYTE_W-1:0] C_WCFG   = 8'hD2;
  localparam logic [BYTE_W-1:0] C_BRST   = 8'hB4;
  localparam logic [BYTE_W-1:0] C_BIT    = 8'h87;
  localparam logic [BYTE_W-1:0] C_WBYTE  = 8'hA5;
  localparam logic [BYTE_W-1:0] C_RBYTE  = 8'h96;
  localparam logic [BYTE_W-1:0] C_TRIP   = 8'h78;

  localparam logic [BYTE_W-1:0] P_STAT = 8'hF0;
  localparam logic [BYTE_W-1:0] P_RDAT = 8'hE1;
  localparam logic [BYTE_W-1:0] P_CFG  = 8'hC3;

  localparam int ST_BUSY = 0;
  localparam int ST_PPD  = 1;
  localparam int ST_SD   = 2;
  localparam int ST_LL   = 3;
  localparam int ST_RST  = 4;
  localparam int ST_SBR  = 5;
  localparam int ST_TSB  = 6;
  localparam int ST_DIR  = 7;
  localparam int CF_SPU  = 2;

  localparam logic [BYTE_W-1:0] ST_RESET_IMG = BYTE_W'(1) << ST_RST;

  typedef enum logic [1:0] {SEL_STAT, SEL_RDAT, SEL_CFG} sel_e;
  typedef enum logic [2:0] {OP_BRST = 3'd0, OP_BIT = 3'd1, OP_WBYTE = 3'd2,
                            OP_RBYTE = 3'd3, OP_TRIP = 3'd4} op_e;

  function automatic logic cmd_known(input logic [BYTE_W-1:0] c);
    case (c)
      C_DEVRST, C_SETPTR, C_WCFG, C_BRST, C_BIT, C_WBYTE, C_RBYTE, C_TRIP: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic cmd_needs_idle(input logic [BYTE_W-1:0] c);
    return cmd_known(c) && (c != C_DEVRST) && (c != C_SETPTR);
  endfunction

  function automatic logic cmd_has_arg(input logic [BYTE_W-1:0] c);
    case (c)
      C_SETPTR, C_WCFG, C_BIT, C_WBYTE, C_TRIP: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic op_e cmd_op(input logic [BYTE_W-1:0] c);
    case (c)
      C_BIT:   return OP_BIT;
      C_WBYTE: return OP_WBYTE;
      C_RBYTE: return OP_RBYTE;
      C_TRIP:  return OP_TRIP;
      default: return OP_BRST;
    endcase
  endfunction

  function automatic logic ptr_ok(input logic [BYTE_W-1:0] p);
    return (p == P_STAT) || (p == P_RDAT) || (p == P_CFG);
  endfunction

  function automatic sel_e ptr_sel(input logic [BYTE_W-1:0] p);
    if (p == P_RDAT) return SEL_RDAT;
    if (p == P_CFG)  return SEL_CFG;
    return SEL_STAT;
  endfunction

  function automatic logic cfg_ok(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1:CFG_W] == ~b[CFG_W-1:0];
  endfunction

  function automatic logic [BYTE_W-1:0] reg_view(input sel_e s,
      input logic [BYTE_W-1:0] st, input logic [BYTE_W-1:0] rd,
      input logic [CFG_W-1:0] cf);
    case (s)
      SEL_RDAT: return rd;
      SEL_CFG:  return {{(BYTE_W-CFG_W){1'b0}}, cf};
      default:  return st;
    endcase
  endfunction
endpackage

// File: rtl/hcr_parser.sv
`timescale 1ns/1ps
module hcr_parser
  import hcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              busy,
  output logic              ack,
  output logic              ev_devrst,
  output logic              ev_setptr,
  output sel_e              new_sel,
  output logic              ev_wcfg,
  output logic [CFG_W-1:0]  new_cfg,
  output logic              ev_launch,
  output op_e               launch_op,
  output logic              op_start,
  output logic [2:0]        op_code,
  output logic [BYTE_W-1:0] op_arg
);
  typedef enum logic [1:0] {PS_CODE, PS_ARG, PS_SINK} pstate_e;

  pstate_e           state, nxt;
  logic [BYTE_W-1:0] pend;
  logic [BYTE_W-1:0] launch_arg;

  always_comb begin
    nxt       = state;
    ack       = 1'b0;
    ev_devrst = 1'b0;
    ev_setptr = 1'b0;
    ev_wcfg   = 1'b0;
    ev_launch = 1'b0;
    new_sel   = ptr_sel(rx_byte);
    new_cfg   = rx_byte[CFG_W-1:0];
    launch_op = cmd_op(state == PS_ARG ? pend : rx_byte);
    launch_arg = (state == PS_ARG) ? rx_byte : '0;
    if (rx_valid) begin
      case (state)
        PS_CODE: begin
          nxt = PS_SINK;
          if (rx_byte == C_DEVRST) begin
            ack = 1'b1;
            ev_devrst = 1'b1;
          end else if (cmd_known(rx_byte) && !(cmd_needs_idle(rx_byte) && busy)) begin
            ack = 1'b1;
            if (cmd_has_arg(rx_byte)) nxt = PS_ARG;
            else ev_launch = 1'b1;
          end
        end
        PS_ARG: begin
          nxt = PS_SINK;
          if (pend == C_SETPTR) begin
            ack = ptr_ok(rx_byte);
            ev_setptr = ptr_ok(rx_byte);
          end else if (pend == C_WCFG) begin
            ack = cfg_ok(rx_byte);
            ev_wcfg = cfg_ok(rx_byte);
          end else begin
            ack = 1'b1;
            ev_launch = 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (bus_start || bus_stop) nxt = PS_CODE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PS_CODE;
      pend     <= '0;
      op_start <= 1'b0;
      op_code  <= '0;
      op_arg   <= '0;
    end else begin
      state    <= nxt;
      if (rx_valid && state == PS_CODE) pend <= rx_byte;
      op_start <= ev_launch;
      if (ev_launch) begin
        op_code <= launch_op;
        op_arg  <= launch_arg;
      end
    end
  end

  assert_busy_nack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && state == PS_CODE && busy && cmd_needs_idle(rx_byte)) |-> !ack);

  assert_sink_nack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && state == PS_SINK) |-> !ack);

  assert_launch_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> $past(!busy));

  assert_discard_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start || bus_stop) |=> state == PS_CODE);
endmodule

// File: rtl/hcr_regs.sv
`timescale 1ns/1ps
module hcr_regs
  import hcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_devrst,
  input  logic              ev_setptr,
  input  sel_e              new_sel,
  input  logic              ev_wcfg,
  input  logic [CFG_W-1:0]  new_cfg,
  input  logic              ev_launch,
  input  op_e               launch_op,
  input  logic              seq_done,
  input  logic              res_presence,
  input  logic              res_short,
  input  logic              res_bit1,
  input  logic              res_bit2,
  input  logic              res_dir,
  input  logic [BYTE_W-1:0] res_data,
  input  logic              spu_end,
  input  logic              rd_begin,
  input  logic              line_in,
  output logic [BYTE_W-1:0] rd_data,
  output logic              busy,
  output logic [CFG_W-1:0]  cfg_bits,
  output logic              abort
);
  logic [BYTE_W-1:0] st;
  logic [BYTE_W-1:0] rdat;
  logic [CFG_W-1:0]  cfg;
  sel_e              sel;
  op_e               cur_op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_RESET_IMG;
      rdat   <= '0;
      cfg    <= '0;
      sel    <= SEL_STAT;
      cur_op <= OP_BRST;
      abort  <= 1'b0;
    end else begin
      abort <= ev_devrst;
      if (ev_devrst) begin
        st  <= ST_RESET_IMG;
        cfg <= '0;
        sel <= SEL_STAT;
      end else begin
        if (spu_end) cfg[CF_SPU] <= 1'b0;
        if (ev_setptr) sel <= new_sel;
        if (ev_wcfg) begin
          cfg       <= new_cfg;
          st[ST_RST] <= 1'b0;
          sel       <= SEL_CFG;
        end
        if (ev_launch) begin
          st[ST_BUSY] <= 1'b1;
          sel         <= SEL_STAT;
          cur_op      <= launch_op;
        end else if (seq_done && st[ST_BUSY]) begin
          st[ST_BUSY] <= 1'b0;
          case (cur_op)
            OP_BRST: begin
              st[ST_PPD] <= res_presence & ~res_short;
              st[ST_SD]  <= res_short;
            end
            OP_BIT:  st[ST_SBR] <= res_bit1;
            OP_TRIP: begin
              st[ST_SBR] <= res_bit1;
              st[ST_TSB] <= res_bit2;
              st[ST_DIR] <= res_dir;
            end
            OP_RBYTE: rdat <= res_data;
            default: ;
          endcase
        end
        if (rd_begin && sel == SEL_STAT) st[ST_LL] <= line_in;
      end
    end
  end

  assign busy     = st[ST_BUSY];
  assign cfg_bits = cfg;
  assign rd_data  = reg_view(sel, st, rdat, cfg);

  assert_devrst_image_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_devrst |=> (st == ST_RESET_IMG && cfg == '0 && sel == SEL_STAT && abort));

  assert_cfg_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wcfg && !spu_end && !ev_devrst) |=> (cfg_bits == $past(new_cfg) && !st[ST_RST]
                                             && rd_data[BYTE_W-1:CFG_W] == '0));

  assert_launch_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_launch && !ev_devrst) |=> (busy && sel == SEL_STAT));

  assert_done_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && busy && !ev_launch && !ev_devrst) |=> !busy);

  assert_short_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st[ST_SD] |-> !st[ST_PPD]);
endmodule

// File: rtl/hcr_top.sv
`timescale 1ns/1ps
module hcr_top
  import hcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              ack,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              rd_begin,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              line_in,
  output logic              op_start,
  output logic [2:0]        op_code,
  output logic [BYTE_W-1:0] op_arg,
  input  logic              seq_done,
  input  logic              res_presence,
  input  logic              res_short,
  input  logic              res_bit1,
  input  logic              res_bit2,
  input  logic              res_dir,
  input  logic [BYTE_W-1:0] res_data,
  input  logic              spu_end,
  output logic              abort,
  output logic [CFG_W-1:0]  cfg_bits
);
  logic             busy;
  logic             ev_devrst, ev_setptr, ev_wcfg, ev_launch;
  sel_e             new_sel;
  logic [CFG_W-1:0] new_cfg;
  op_e              launch_op;

  hcr_parser u_parser (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .bus_start(bus_start), .bus_stop(bus_stop), .busy(busy), .ack(ack),
    .ev_devrst(ev_devrst), .ev_setptr(ev_setptr), .new_sel(new_sel),
    .ev_wcfg(ev_wcfg), .new_cfg(new_cfg), .ev_launch(ev_launch),
    .launch_op(launch_op), .op_start(op_start), .op_code(op_code), .op_arg(op_arg)
  );

  hcr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .ev_devrst(ev_devrst), .ev_setptr(ev_setptr),
    .new_sel(new_sel), .ev_wcfg(ev_wcfg), .new_cfg(new_cfg),
    .ev_launch(ev_launch), .launch_op(launch_op), .seq_done(seq_done),
    .res_presence(res_presence), .res_short(res_short), .res_bit1(res_bit1),
    .res_bit2(res_bit2), .res_dir(res_dir), .res_data(res_data),
    .spu_end(spu_end), .rd_begin(rd_begin), .line_in(line_in),
    .rd_data(rd_data), .busy(busy), .cfg_bits(cfg_bits), .abort(abort)
  );

  assert_onehot_events_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_devrst, ev_setptr, ev_wcfg, ev_launch}));
endmodule

// File: tb/tb_hcr_top.sv
`timescale 1ns/1ps
module tb_hcr_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0, bus_start = 1'b0, bus_stop = 1'b0, rd_begin = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic line_in = 1'b0, spu_end = 1'b0;
  logic seq_done = 1'b0;
  logic res_presence = 1'b0, res_short = 1'b0, res_bit1 = 1'b0, res_bit2 = 1'b0, res_dir = 1'b0;
  logic [7:0] res_data = 8'h00;
  logic ack, op_start, abort;
  logic [2:0] op_code;
  logic [7:0] op_arg, rd_data;
  logic [3:0] cfg_bits;

  int n_chk = 0, n_err = 0;
  int n_launch = 0;
  int seq_cnt = 0;
  int seq_dly = 20;
  logic [2:0] last_op = 3'd7;
  logic [7:0] last_arg = 8'h00;
  int n_abort = 0;

  always #10 clk = ~clk;

  hcr_top dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte), .ack(ack),
    .bus_start(bus_start), .bus_stop(bus_stop), .rd_begin(rd_begin), .rd_data(rd_data),
    .line_in(line_in), .op_start(op_start), .op_code(op_code), .op_arg(op_arg),
    .seq_done(seq_done), .res_presence(res_presence), .res_short(res_short),
    .res_bit1(res_bit1), .res_bit2(res_bit2), .res_dir(res_dir), .res_data(res_data),
    .spu_end(spu_end), .abort(abort), .cfg_bits(cfg_bits)
  );

  // Sequencer model: completes each operation seq_dly cycles after launch.
  always @(posedge clk) begin
    seq_done <= 1'b0;
    if (abort) seq_cnt <= 0;
    else if (op_start) begin
      seq_cnt  <= seq_dly;
      last_op  <= op_code;
      last_arg <= op_arg;
      n_launch <= n_launch + 1;
    end else if (seq_cnt != 0) begin
      seq_cnt <= seq_cnt - 1;
      if (seq_cnt == 1) seq_done <= 1'b1;
    end
    if (abort) n_abort <= n_abort + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tx(input logic [7:0] b, output logic a);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    #2 a = ack;
    @(posedge clk);
    #1 rx_valid = 1'b0;
  endtask

  task automatic start_ev;
    @(negedge clk); bus_start = 1'b1;
    @(posedge clk); #1 bus_start = 1'b0;
  endtask

  task automatic stop_ev;
    @(negedge clk); bus_stop = 1'b1;
    @(posedge clk); #1 bus_stop = 1'b0;
  endtask

  task automatic read_access;
    @(negedge clk); rd_begin = 1'b1;
    @(posedge clk); #1 rd_begin = 1'b0;
    @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] c, input logic ea, input string tag);
    logic a;
    start_ev(); tx(c, a); chk(tag, a, ea); stop_ev(); @(negedge clk);
  endtask

  task automatic cmd2(input logic [7:0] c, input logic [7:0] p,
                      input logic ea1, input logic ea2, input string tag);
    logic a;
    start_ev(); tx(c, a); chk(tag, a, ea1); tx(p, a); chk(tag, a, ea2);
    stop_ev(); @(negedge clk);
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (rd_data[0] == 1'b0) break;
    end
  endtask

  function automatic logic good_cfg(input logic [7:0] b);
    return (b >> 4) == ((~b) & 8'h0F);
  endfunction

  function automatic logic good_ptr(input logic [7:0] p);
    return p == 8'hF0 || p == 8'hE1 || p == 8'hC3;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [3:0] exp_cfg;
    logic [7:0] exp_ptr_val;
    logic [7:0] st_img;
    logic a;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 status after reset", rd_data, 8'h10);
    chk("R1 cfg port after reset", cfg_bits, 4'h0);
    cmd2(8'hE1, 8'hC3, 1'b1, 1'b1, "R1 R3 select cfg");
    chk("R1 cfg reads 00", rd_data, 8'h00);

    // R4 sweep over every configuration byte
    exp_cfg = 4'h0;
    for (int b = 0; b < 256; b++) begin
      cmd2(8'hD2, 8'(b), 1'b1, good_cfg(8'(b)), "R4 cfg write ack");
      if (good_cfg(8'(b))) exp_cfg = 4'(b);
      chk("R4 cfg readback", rd_data, {4'h0, exp_cfg});
    end
    cmd2(8'hE1, 8'hF0, 1'b1, 1'b1, "R3 select status");
    chk("R4 reset flag cleared", rd_data[4], 1'b0);

    // R2 R7 R8 byte read
    res_data = 8'h3C;
    base = n_launch;
    cmd1(8'h96, 1'b1, "R2 byte read code");
    @(negedge clk);
    chk("R2 byte read launched", n_launch - base, 1);
    chk("R2 byte read opcode", last_op, 3'd3);
    chk("R7 busy during op", rd_data[0], 1'b1);
    wait_idle();
    chk("R7 busy cleared", rd_data[0], 1'b0);
    cmd2(8'hE1, 8'hE1, 1'b1, 1'b1, "R3 select read data");
    chk("R8 read data loaded", rd_data, 8'h3C);

    // R10 line level sampling
    cmd2(8'hD2, 8'hA5, 1'b1, 1'b1, "R4 cfg 5");
    cmd2(8'hE1, 8'hF0, 1'b1, 1'b1, "R3 select status");
    line_in = 1'b1;
    read_access();
    chk("R10 line level sampled", rd_data[3], 1'b1);
    read_access();
    chk("R10 repeated read", rd_data, 8'h08);
    cmd2(8'hE1, 8'hC3, 1'b1, 1'b1, "R3 select cfg");
    line_in = 1'b0;
    read_access();
    read_access();
    chk("R10 repeated cfg read", rd_data, 8'h05);
    cmd2(8'hE1, 8'hF0, 1'b1, 1'b1, "R3 select status");
    chk("R10 not sampled off status", rd_data[3], 1'b1);

    // R3 sweep over every pointer byte: status=08, read data=3C, cfg=05
    exp_ptr_val = 8'h08;
    for (int p = 0; p < 256; p++) begin
      cmd2(8'hE1, 8'(p), 1'b1, good_ptr(8'(p)), "R3 pointer ack");
      if (p == 8'hF0) exp_ptr_val = 8'h08;
      else if (p == 8'hE1) exp_ptr_val = 8'h3C;
      else if (p == 8'hC3) exp_ptr_val = 8'h05;
      chk("R3 pointer selects", rd_data, exp_ptr_val);
    end

    // R2 R8 bus reset with presence, then with a short
    cmd2(8'hE1, 8'hC3, 1'b1, 1'b1, "R3 select cfg");
    res_presence = 1'b1; res_short = 1'b0;
    cmd1(8'hB4, 1'b1, "R2 bus reset code");
    chk("R7 pointer to status", rd_data[0], 1'b1);
    wait_idle();
    chk("R2 bus reset opcode", last_op, 3'd0);
    chk("R8 presence", rd_data[2:1], 2'b01);
    res_short = 1'b1;
    cmd1(8'hB4, 1'b1, "R2 bus reset code");
    wait_idle();
    chk("R8 short masks presence", rd_data[2:1], 2'b10);

    // R2 R8 single bit
    res_bit1 = 1'b1;
    cmd2(8'h87, 8'h80, 1'b1, 1'b1, "R2 single bit");
    wait_idle();
    chk("R2 single bit opcode", last_op, 3'd1);
    chk("R2 single bit arg", last_arg, 8'h80);
    chk("R8 single bit result", rd_data[5], 1'b1);

    // R2 R8 triplet
    res_bit1 = 1'b0; res_bit2 = 1'b1; res_dir = 1'b1;
    cmd2(8'h78, 8'h00, 1'b1, 1'b1, "R2 triplet");
    wait_idle();
    chk("R2 triplet opcode", last_op, 3'd4);
    chk("R8 triplet bits", rd_data[7:5], 3'b110);

    // R2 R8 byte write leaves results
    res_bit2 = 1'b0; res_dir = 1'b0; res_bit1 = 1'b1;
    cmd2(8'hA5, 8'h5A, 1'b1, 1'b1, "R2 byte write");
    wait_idle();
    chk("R2 byte write opcode", last_op, 3'd2);
    chk("R2 byte write arg", last_arg, 8'h5A);
    chk("R8 byte write no result", rd_data[7:5], 3'b110);

    // R5 sweep over every code while busy
    seq_dly = 6000;
    cmd1(8'h96, 1'b1, "R5 long byte read");
    base = n_launch;
    for (int c = 0; c < 256; c++) begin
      if (c != 8'hF0) cmd1(8'(c), (c == 8'hE1), "R5 R9 code while busy");
    end
    chk("R5 nothing launched while busy", n_launch - base, 0);
    chk("R5 still busy", rd_data[0], 1'b1);
    cmd2(8'hE1, 8'hC3, 1'b1, 1'b1, "R5 pointer while busy");
    chk("R5 cfg unchanged while busy", rd_data, 8'h05);

    // R6 device reset while busy
    base = n_abort;
    cmd1(8'hF0, 1'b1, "R6 device reset");
    chk("R6 abort pulsed", n_abort - base, 1);
    chk("R6 status image", rd_data, 8'h10);
    chk("R6 cfg port cleared", cfg_bits, 4'h0);
    seq_dly = 20;

    // R9 extra bytes and unknown codes
    start_ev(); tx(8'hD2, a); tx(8'h3C, a);
    chk("R9 cfg accepted", a, 1'b1);
    tx(8'h00, a); chk("R9 extra byte nacked", a, 1'b0);
    stop_ev(); @(negedge clk);
    chk("R9 cfg after extra byte", rd_data, 8'h0C);
    cmd1(8'h11, 1'b0, "R9 unknown code");
    chk("R9 unknown no effect", rd_data, 8'h0C);

    // R11 partial command discarded by stop and by repeated start
    start_ev(); tx(8'hD2, a); stop_ev();
    start_ev(); tx(8'h1E, a); chk("R11 stop discards", a, 1'b0); stop_ev();
    @(negedge clk);
    chk("R11 cfg unchanged", rd_data, 8'h0C);
    start_ev(); tx(8'hD2, a); start_ev();
    tx(8'h1E, a); chk("R11 restart discards", a, 1'b0); stop_ev();
    @(negedge clk);
    chk("R11 cfg unchanged again", rd_data, 8'h0C);

    // R12 strong pullup clear
    @(negedge clk); spu_end = 1'b1;
    @(posedge clk); #1 spu_end = 1'b0;
    @(negedge clk);
    chk("R12 spu bit cleared", rd_data, 8'h08);
    chk("R12 cfg port", cfg_bits, 4'h8);
    cmd2(8'hE1, 8'hF0, 1'b1, 1'b1, "R3 select status");
    st_img = rd_data;
    chk("R1 reset flag cleared by cfg write", st_img[4], 1'b0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule